// File: doc/BRIEF.md
# Video Line Timing and Interrupt Flags

This block is the raster timebase of a tile-based video display processor. It counts master clocks across each scanline and scanlines across each frame. From those two counts it derives the vertical-interrupt pending flag, the horizontal-interrupt down-counter and its pending flag, and a four-bit status word.

Two horizontal resolutions are supported: a wide mode with 16-clock access slots and a narrow mode with 20-clock slots. Two video standards are supported, each with its own active and total line counts. Resolution and standard are captured once per frame, so a change made mid-frame only takes effect from the next frame. In wide mode the sync region is not a whole number of slots. It adds a 332-clock stretch after slot 21, which is why the interrupt point and the hblank-clear point sit at irregular clock offsets.

An interrupt controller reads the pending flags and clears each one with a single-cycle acknowledge. The CPU reads `status_o` to learn the blanking and DMA state.

Top module: `vid_line_timing`

## Requirements
- R1: `hpos_o` counts from 0 to LINE_CLKS-1 (default 3420) and then returns to 0. `line_o` advances by one in the same cycle that `hpos_o` returns to 0.
- R2: `line_o` returns to 0 after the last line of the latched standard: TOT_NTSC (default 262) or TOT_PAL (default 313). `wide_i` and `pal_i` are sampled only at that frame wrap. Reset latches narrow resolution with the NTSC standard.
- R3: `vint_pend_o` becomes 1 one cycle after the cycle in which `line_o` equals the active line count of the latched standard and `hpos_o` equals 812 (wide) or 1200 (narrow). Active line counts default to 224 for NTSC and 240 for PAL.
- R4: `vint_irq_o` is 1 exactly when `vint_pend_o` is 1 and `vint_en_i` is 1. The pending flag is set whether or not `vint_en_i` is 1.
- R5: In the last clock of an active line (`line_o` below the active count), the H-interrupt counter behaves as follows. If it is 0, `hint_pend_o` sets and the counter reloads from `hint_reload_i`. Otherwise the counter decrements. In the last clock of any other line the counter reloads. At all other times it holds. Reset value is 0.
- R6: `status_o[3]` is 1 while `line_o` is at or above the active line count of the latched standard.
- R7: `status_o[2]` is 1 while `hpos_o` is below 912 (wide) or 890 (narrow).
- R8: `status_o[1]` follows `dma_busy_i` in the same cycle. `status_o[0]` is always 0.
- R9: A pending flag clears one cycle after its acknowledge pulse. An acknowledge in the same cycle as a set event loses, and the flag stays 1.
- R10: During reset, `hpos_o`, `line_o`, `hint_cnt_o` and both pending flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| wide_i | input | 1 | resolution select: 1 = wide, 0 = narrow |
| pal_i | input | 1 | standard select: 1 = PAL, 0 = NTSC |
| vint_en_i | input | 1 | vertical interrupt enable |
| hint_reload_i | input | HCW | H-interrupt reload value |
| dma_busy_i | input | 1 | DMA engine running |
| vint_ack_i | input | 1 | clear vertical pending flag |
| hint_ack_i | input | 1 | clear horizontal pending flag |
| hpos_o | output | HW | master clock within line |
| line_o | output | LW | line within frame |
| vint_pend_o | output | 1 | vertical interrupt pending |
| vint_irq_o | output | 1 | gated vertical interrupt request |
| hint_pend_o | output | 1 | horizontal interrupt pending |
| hint_cnt_o | output | HCW | H-interrupt down-counter |
| status_o | output | 4 | {vblank, hblank, dma, 0} |

## Verification
The assertions assume three things about the environment. First, acknowledges are one-cycle pulses. Second, the mode inputs may change at any time, since the latch alone keeps them out of the frame. Third, `hint_reload_i` holds its value through the cycle that reloads the counter.

The bench changes resolution and standard in the middle of frames, toggles the enable and the reload value across frames, and sends acknowledges both at random and deliberately in the exact cycle of a set event. To keep runs short, the bench uses small line counts. The per-line clock points keep their real values.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
  localparam int unsigned SLOT_WIDE        = 16;
  localparam int unsigned SLOT_NARROW      = 20;
  localparam int unsigned SYNC_SLOT_WIDE   = 21;
  localparam int unsigned SYNC_STRETCH     = 332;
  localparam int unsigned POST_SLOTS_WIDE  = 9;
  localparam int unsigned VINT_SLOTS_NARR  = 33 + 20 + 7;
  localparam int unsigned SYNC_END_SLOT_N  = 33;
  // sync end points
  localparam int unsigned SYNC_END_WIDE    = SYNC_SLOT_WIDE * SLOT_WIDE + SYNC_STRETCH;   // 668
  localparam int unsigned SYNC_END_NARR    = SYNC_END_SLOT_N * SLOT_NARROW;               // 660
  localparam int unsigned VINT_CLK_WIDE    = SYNC_END_WIDE + POST_SLOTS_WIDE * SLOT_WIDE; // 812
  localparam int unsigned VINT_CLK_NARR    = VINT_SLOTS_NARR * SLOT_NARROW;               // 1200
  localparam int unsigned HBL_CLR_WIDE     = SYNC_END_WIDE + 61 * 4;                      // 912
  localparam int unsigned HBL_CLR_NARR     = SYNC_END_NARR + 46 * 5;                      // 890

  typedef struct packed {
    logic wide;
    logic pal;
  } mode_t;
endpackage

// File: rtl/vlt_raster.sv
module vlt_raster
  import vlt_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 3420,
  parameter int unsigned TOT_NTSC  = 262,
  parameter int unsigned TOT_PAL   = 313,
  parameter int unsigned HW        = 12,
  parameter int unsigned LW        = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_t         mode_i,
  output logic [HW-1:0] hpos_o,
  output logic [LW-1:0] line_o,
  output mode_t         mode_q_o,
  output logic          line_end_o
);
  localparam logic [HW-1:0] HLAST  = HW'(LINE_CLKS - 1);
  localparam logic [LW-1:0] LLAST_N = LW'(TOT_NTSC - 1);
  localparam logic [LW-1:0] LLAST_P = LW'(TOT_PAL - 1);

  logic frame_end;
  assign line_end_o = (hpos_o == HLAST);
  assign frame_end  = line_end_o && (line_o == (mode_q_o.pal ? LLAST_P : LLAST_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hpos_o   <= '0;
      line_o   <= '0;
      mode_q_o <= '0;
    end else begin
      hpos_o <= line_end_o ? '0 : hpos_o + 1'b1;
      if (frame_end) begin
        line_o   <= '0;
        mode_q_o <= mode_i;
      end else if (line_end_o) begin
        line_o <= line_o + 1'b1;
      end
    end
  end

  // R1
  hpos_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> hpos_o == '0);
  // R1
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |=> $stable(line_o));
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(mode_q_o));
endmodule

// File: rtl/vlt_hint.sv
module vlt_hint #(
  parameter int unsigned HCW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           line_end_i,
  input  logic           active_i,
  input  logic [HCW-1:0] reload_i,
  output logic [HCW-1:0] cnt_o,
  output logic           fire_o
);
  assign fire_o = line_end_i && active_i && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (line_end_i) begin
      if (!active_i || fire_o)        cnt_o <= reload_i;
      else                            cnt_o <= cnt_o - 1'b1;
    end
  end

  // R5
  hcnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(cnt_o));
  // R5
  hcnt_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_o == $past(reload_i));
endmodule

// File: rtl/vlt_pend.sv
module vlt_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;   // set beats ack
    else if (ack_i) pend_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !pend_o);
  // R3
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(set_i));
endmodule

// File: rtl/vid_line_timing.sv
module vid_line_timing
  import vlt_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 3420,
  parameter int unsigned ACT_NTSC  = 224,
  parameter int unsigned ACT_PAL   = 240,
  parameter int unsigned TOT_NTSC  = 262,
  parameter int unsigned TOT_PAL   = 313,
  parameter int unsigned HCW       = 8,
  parameter int unsigned HW        = $clog2(LINE_CLKS),
  parameter int unsigned LW        = $clog2((TOT_PAL > TOT_NTSC) ? TOT_PAL : TOT_NTSC)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wide_i,
  input  logic           pal_i,
  input  logic           vint_en_i,
  input  logic [HCW-1:0] hint_reload_i,
  input  logic           dma_busy_i,
  input  logic           vint_ack_i,
  input  logic           hint_ack_i,
  output logic [HW-1:0]  hpos_o,
  output logic [LW-1:0]  line_o,
  output logic           vint_pend_o,
  output logic           vint_irq_o,
  output logic           hint_pend_o,
  output logic [HCW-1:0] hint_cnt_o,
  output logic [3:0]     status_o
);
  localparam logic [LW-1:0] ACT_N_L = LW'(ACT_NTSC);
  localparam logic [LW-1:0] ACT_P_L = LW'(ACT_PAL);
  localparam logic [HW-1:0] VPT_W   = HW'(VINT_CLK_WIDE);
  localparam logic [HW-1:0] VPT_N   = HW'(VINT_CLK_NARR);
  localparam logic [HW-1:0] HBC_W   = HW'(HBL_CLR_WIDE);
  localparam logic [HW-1:0] HBC_N   = HW'(HBL_CLR_NARR);
  localparam int unsigned   NFLAG   = 2;

  mode_t          mode_in, mode_q;
  logic           line_end, vblank, hblank, hint_fire;
  logic [LW-1:0]  act_lines;
  logic [NFLAG-1:0] f_set, f_ack, f_pend;

  assign mode_in = '{wide: wide_i, pal: pal_i};

  vlt_raster #(.LINE_CLKS(LINE_CLKS), .TOT_NTSC(TOT_NTSC), .TOT_PAL(TOT_PAL),
               .HW(HW), .LW(LW)) i_raster (
    .clk_i, .rst_ni, .mode_i(mode_in), .hpos_o, .line_o,
    .mode_q_o(mode_q), .line_end_o(line_end)
  );

  assign act_lines = mode_q.pal ? ACT_P_L : ACT_N_L;
  assign vblank    = (line_o >= act_lines);
  assign hblank    = (hpos_o < (mode_q.wide ? HBC_W : HBC_N));

  vlt_hint #(.HCW(HCW)) i_hint (
    .clk_i, .rst_ni, .line_end_i(line_end), .active_i(!vblank),
    .reload_i(hint_reload_i), .cnt_o(hint_cnt_o), .fire_o(hint_fire)
  );

  assign f_set[0] = (line_o == act_lines) && (hpos_o == (mode_q.wide ? VPT_W : VPT_N));
  assign f_set[1] = hint_fire;
  assign f_ack    = {hint_ack_i, vint_ack_i};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    vlt_pend i_pend (.clk_i, .rst_ni, .set_i(f_set[g]), .ack_i(f_ack[g]), .pend_o(f_pend[g]));
  end

  assign vint_pend_o = f_pend[0];
  assign hint_pend_o = f_pend[1];
  assign vint_irq_o  = vint_pend_o & vint_en_i;
  assign status_o    = {vblank, hblank, dma_busy_i, 1'b0};
endmodule

// File: tb/test_vid_line_timing.sv
module test_vid_line_timing;
  localparam int LC = 3420, AN = 3, AP = 4, TN = 5, TP = 6;
  localparam int RUN = 140000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide, pal, ven, dma, vack, hack;
  logic [7:0] reload;
  logic [11:0] hpos;
  logic [2:0] line;
  logic vpend, virq, hpend;
  logic [7:0] hcnt;
  logic [3:0] status;

  always #2.5ns clk = ~clk;

  vid_line_timing #(.LINE_CLKS(LC), .ACT_NTSC(AN), .ACT_PAL(AP), .TOT_NTSC(TN), .TOT_PAL(TP))
  i_vid_line_timing (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .pal_i(pal), .vint_en_i(ven),
    .hint_reload_i(reload), .dma_busy_i(dma), .vint_ack_i(vack), .hint_ack_i(hack),
    .hpos_o(hpos), .line_o(line), .vint_pend_o(vpend), .vint_irq_o(virq),
    .hint_pend_o(hpend), .hint_cnt_o(hcnt), .status_o(status)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  // reference model state
  int m_h, m_l, m_w, m_p, m_hc, m_vp, m_hp;
  bit m_vack_last, m_hack_last;

  function automatic int vpt(int w); return w ? 812 : 1200; endfunction
  function automatic int hclr(int w); return w ? 912 : 890; endfunction
  function automatic int actl(int p); return p ? AP : AN; endfunction
  function automatic int totl(int p); return p ? TP : TN; endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_l = 0; m_w = 0; m_p = 0; m_hc = 0; m_vp = 0; m_hp = 0;
      m_vack_last = 0; m_hack_last = 0;
    end else begin
      automatic bit lend = (m_h == LC - 1);
      automatic bit act  = (m_l < actl(m_p));
      automatic bit vset = (m_l == actl(m_p)) && (m_h == vpt(m_w));
      automatic bit hset = lend && act && (m_hc == 0);
      if (vset) m_vp = 1; else if (vack) m_vp = 0;
      if (hset) m_hp = 1; else if (hack) m_hp = 0;
      m_vack_last = vack; m_hack_last = hack;
      if (lend) m_hc = (!act || m_hc == 0) ? int'(reload) : m_hc - 1;
      if (lend) begin
        m_h = 0;
        if (m_l == totl(m_p) - 1) begin
          m_l = 0; m_w = wide; m_p = pal;   // R2 latch at frame wrap
        end else m_l++;
      end else m_h++;
    end
  end

  task automatic compare_all();
    chk("R1 hpos", int'(hpos), m_h);
    chk("R2 line", int'(line), m_l);
    chk(m_vack_last ? "R9 vint_pend" : "R3 vint_pend", int'(vpend), m_vp);
    chk("R4 vint_irq", int'(virq), m_vp & int'(ven));
    chk(m_hack_last ? "R9 hint_pend" : "R5 hint_pend", int'(hpend), m_hp);
    chk("R5 hint_cnt", int'(hcnt), m_hc);
    chk("R6 vblank", int'(status[3]), int'(m_l >= actl(m_p)));
    chk("R7 hblank", int'(status[2]), int'(m_h < hclr(m_w)));
    chk("R8 dma/bit0", int'(status[1:0]), int'(dma) * 2);
  endtask

  initial begin
    wide = 1; pal = 1; ven = 0; dma = 0; vack = 0; hack = 0; reload = 8'd1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 hpos", int'(hpos), 0);
    chk("R10 line", int'(line), 0);
    chk("R10 hint_cnt", int'(hcnt), 0);
    chk("R10 pend", int'({vpend, hpend}), 0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN; c++) begin
      @(negedge clk);
      compare_all();
      wide   = ((c / 25000) % 2) == 0;
      pal    = ((c / 37000) % 2) == 0;
      ven    = ((c / 9000) % 2) == 1;
      reload = 8'((c / 20000) % 3);
      dma    = ((c / 700) % 3) == 0;
      vack   = ($urandom % 16) == 0;
      hack   = ($urandom % 16) == 0;
      // R9 directed: acknowledge in the set cycle
      if (((c / 30000) % 2) == 1) begin
        if (m_l == actl(m_p) && m_h == vpt(m_w)) vack = 1;
        if (m_h == LC - 1 && m_l < actl(m_p) && m_hc == 0) hack = 1;
      end
    end
    @(negedge clk);
    compare_all();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(190000 * 5ns);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule